// File: doc/BRIEF.md
# Unsigned Sequential Divider with Accumulator-Style Flags

This block divides an unsigned dividend by an unsigned divisor of the same width. It computes one quotient bit per clock by restoring shift-and-subtract. A short pulse on the start input launches a division. The quotient comes back on the accumulator-side output and the remainder on the second-operand output. The block also drives a carry flag and an overflow flag, and it reports progress with a busy level and a one-cycle done pulse.

The latency is fixed. It is the number of machine cycles per divide times the number of clocks per machine cycle, and the defaults give 4 x 3 = 12 clocks. Idle clocks after the last iteration fill out the count, so a caller can schedule around a constant delay whatever the operands are. The results and flags are registered. They change only in the cycle when done is raised and hold until the next division completes.

A zero divisor raises the overflow flag and still completes in the same time. Its results are deterministic: the quotient is all ones and the remainder equals the dividend. The carry flag is cleared on every division. The reset input is asynchronous and active low, and two flops release it internally in step with the clock.

Top module: `udiv_unit`

## Requirements
- R1: For a nonzero divisor, quot_o holds the integer part of dividend_i / divisor_i from the completed division. For example, 251 / 18 gives 13 (0x0D).
- R2: For a nonzero divisor, rem_o holds dividend_i modulo divisor_i and is less than the divisor. For example, 251 / 18 leaves 17 (0x11).
- R3: carry_o is 0 after reset and after every completed division, including a division by zero.
- R4: ovf_o is 0 after a division whose divisor was nonzero, even when the previous division set it.
- R5: When the divisor is zero, ovf_o is 1, quot_o is all ones (0xFF at width 8) and rem_o equals the dividend.
- R6: done_o is high for exactly one clock. It rises MACH_CYCLES*CLK_PER_MACH clock edges after the edge that accepted start_i. busy_o is high from the edge after acceptance until the edge that raises done_o, and it is low while done_o is high.
- R7: A start_i pulse that arrives while busy_o is high is ignored. The running division keeps its operands, its result and its latency, and no second division follows it.
- R8: quot_o, rem_o and ovf_o keep their values from one done_o pulse to the next, including the whole time a later division is running.
- R9: While rst_n is low, quot_o, rem_o, carry_o, ovf_o, busy_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches a division when the unit is idle |
| dividend_i | input | WIDTH | Unsigned dividend (accumulator operand) |
| divisor_i | input | WIDTH | Unsigned divisor (second operand) |
| quot_o | output | WIDTH | Quotient from the last completed division |
| rem_o | output | WIDTH | Remainder from the last completed division |
| carry_o | output | 1 | Carry flag, cleared by every division |
| ovf_o | output | 1 | Overflow flag, set only for a zero divisor |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the default instance, with width 8 and 4 machine cycles of 3 clocks each. It uses that instance for the worked example, the edge operands, a zero divisor, a start that arrives while busy, and the holding of results. It also builds a second instance with width 4 and 4 machine cycles of 2 clocks each. That small width lets the bench try every dividend and divisor pair, zero divisors included, so every path through the restoring step and the padded latency is exercised.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } udiv_state_e;
endpackage

// File: rtl/udiv_rst_sync.sv
module udiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
  import udiv_pkg::*;
#(
  parameter int W   = 8,
  parameter int LAT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(LAT);

  udiv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    load_o  = (state_q == ST_IDLE) && start_i;
    step_o  = (state_q == ST_RUN) && (cnt_q < CW'(W));
    fin_o   = (state_q == ST_RUN) && (cnt_q == CW'(LAT - 1));
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = fin_o;
    if (load_o) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (fin_o) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (state_q == ST_RUN) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/udiv_dp.sv
module udiv_dp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         fin_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] dsr_q;
  logic [W-1:0] work_q, work_d;
  logic [W-1:0] part_q, part_d;
  logic [W:0]   shifted;
  logic [W-1:0] diff;
  logic         fits;
  logic         zero_div;

  // Restoring step: bring in the next dividend bit, subtract when it fits.
  // The quotient bits collect in work_q as the dividend shifts out of it.
  always_comb begin
    shifted  = {part_q, work_q[W-1]};
    fits     = (shifted >= {1'b0, dsr_q});
    diff     = shifted[W-1:0] - dsr_q;
    zero_div = (dsr_q == '0);
    work_d   = work_q;
    part_d   = part_q;
    if (load_i) begin
      work_d = dividend_i;
      part_d = '0;
    end else if (step_i) begin
      work_d = {work_q[W-2:0], fits};
      part_d = fits ? diff : shifted[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsr_q  <= '0;
      work_q <= '0;
      part_q <= '0;
    end else begin
      if (load_i) dsr_q <= divisor_i;
      work_q <= work_d;
      part_q <= part_d;
    end
  end

  // Result stage. With a zero divisor every trial fits, so the loop gives
  // an all-ones quotient and a remainder equal to the dividend by itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_o  <= '0;
      rem_o   <= '0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else if (fin_i) begin
      quot_o  <= work_q;
      rem_o   <= part_q;
      carry_o <= 1'b0;
      ovf_o   <= zero_div;
    end
  end
endmodule

// File: rtl/udiv_unit.sv
module udiv_unit #(
  parameter int WIDTH        = 8,
  parameter int MACH_CYCLES  = 4,
  parameter int CLK_PER_MACH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             busy_o,
  output logic             done_o
);
  // LAT must be at least WIDTH + 1 so the iterations end before completion.
  localparam int LAT = MACH_CYCLES * CLK_PER_MACH;

  logic rst_int_n;
  logic load, step, fin;

  udiv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  udiv_ctrl #(.W(WIDTH), .LAT(LAT)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .fin_o   (fin),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  udiv_dp #(.W(WIDTH)) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (load),
    .step_i     (step),
    .fin_i      (fin),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quot_o     (quot_o),
    .rem_o      (rem_o),
    .carry_o    (carry_o),
    .ovf_o      (ovf_o)
  );
endmodule

// File: rtl/udiv_chk.sv
module udiv_chk #(
  parameter int W   = 8,
  parameter int LAT = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic [W-1:0] quot_o,
  input logic [W-1:0] rem_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         busy_o,
  input logic         done_o
);
  localparam int LW = $clog2(LAT + 1);

  logic [W-1:0]   dvd_seen, dsr_seen;
  logic [LW-1:0]  lat_q;
  logic [2*W-1:0] recon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_seen <= '0;
      dsr_seen <= '0;
      lat_q    <= '0;
    end else if (start_i && !busy_o) begin
      dvd_seen <= dividend_i;
      dsr_seen <= divisor_i;
      lat_q    <= '0;
    end else if (busy_o) begin
      lat_q    <= lat_q + 1'b1;
    end
  end

  assign recon = {{W{1'b0}}, quot_o} * {{W{1'b0}}, dsr_seen} + {{W{1'b0}}, rem_o};

  AST_QUOT_RECON: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ovf_o) |-> (recon == {{W{1'b0}}, dvd_seen})); // R1
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ovf_o) |-> (rem_o < dsr_seen)); // R2
  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !carry_o); // R3
  AST_OVF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ovf_o == (dsr_seen == '0))); // R4
  AST_ZERO_DIV_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (dsr_seen == '0)) |-> ((quot_o == '1) && (rem_o == dvd_seen))); // R5
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == LW'(LAT))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(ovf_o))); // R8
endmodule

bind udiv_unit udiv_chk #(.W(WIDTH), .LAT(MACH_CYCLES * CLK_PER_MACH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .quot_o     (quot_o),
  .rem_o      (rem_o),
  .carry_o    (carry_o),
  .ovf_o      (ovf_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_udiv_unit.sv
`timescale 1ns/1ps
module sim_udiv_unit;
  localparam int LAT0 = 12;
  localparam int LAT1 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       s0_start = 1'b0;
  logic [7:0] s0_a = '0, s0_b = '0;
  logic [7:0] q0, r0;
  logic       c0, v0, busy0, done0;

  logic       s1_start = 1'b0;
  logic [3:0] s1_a = '0, s1_b = '0;
  logic [3:0] q1, r1;
  logic       c1, v1, busy1, done1;

  int total = 0;
  int bad   = 0;

  udiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(s0_start), .dividend_i(s0_a), .divisor_i(s0_b),
    .quot_o(q0), .rem_o(r0), .carry_o(c0), .ovf_o(v0), .busy_o(busy0), .done_o(done0)
  );

  udiv_unit #(.WIDTH(4), .MACH_CYCLES(4), .CLK_PER_MACH(2)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(s1_start), .dividend_i(s1_a), .divisor_i(s1_b),
    .quot_o(q1), .rem_o(r1), .carry_o(c1), .ovf_o(v1), .busy_o(busy1), .done_o(done1)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    s0_start = 1'b1; s0_a = a; s0_b = b;
    @(negedge clk);
    s0_start = 1'b0;
  endtask

  task automatic wait_done(input int already, output int lat);
    lat = already;
    while (!done0 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic div_and_check(input logic [7:0] a, input logic [7:0] b);
    int lat;
    launch(a, b);
    chk("R6", "busy after accept", int'(busy0), 1);
    wait_done(0, lat);
    chk("R6", "latency", lat, LAT0);
    chk("R6", "busy low with done", int'(busy0), 0);
    if (b != 0) begin
      chk("R1", "quotient", int'(q0), int'(a) / int'(b));
      chk("R2", "remainder", int'(r0), int'(a) % int'(b));
      chk("R4", "overflow", int'(v0), 0);
    end else begin
      chk("R5", "zero-div quotient", int'(q0), 255);
      chk("R5", "zero-div remainder", int'(r0), int'(a));
      chk("R5", "zero-div overflow", int'(v0), 1);
    end
    chk("R3", "carry", int'(c0), 0);
    @(negedge clk);
    chk("R6", "done one cycle", int'(done0), 0);
  endtask

  task automatic t_reset;
    chk("R9", "quot in reset", int'(q0), 0);
    chk("R9", "rem in reset", int'(r0), 0);
    chk("R9", "carry in reset", int'(c0), 0);
    chk("R9", "ovf in reset", int'(v0), 0);
    chk("R9", "busy in reset", int'(busy0), 0);
    chk("R9", "done in reset", int'(done0), 0);
  endtask

  task automatic t_example;
    div_and_check(8'd251, 8'd18);
    chk("R1", "251/18 quotient", int'(q0), 13);
    chk("R2", "251/18 remainder", int'(r0), 17);
  endtask

  task automatic t_patterns;
    logic [7:0] av [8] = '{8'd255, 8'd0, 8'd7, 8'd255, 8'd100, 8'd128, 8'd200, 8'd254};
    logic [7:0] bv [8] = '{8'd1, 8'd7, 8'd9, 8'd255, 8'd10, 8'd3, 8'd201, 8'd128};
    for (int i = 0; i < 8; i++) div_and_check(av[i], bv[i]);
  endtask

  task automatic t_zero_div;
    div_and_check(8'hA7, 8'h00);
    div_and_check(8'h00, 8'h00);
    div_and_check(8'd45, 8'd6);
    chk("R4", "ovf cleared after zero-div", int'(v0), 0);
  endtask

  task automatic t_busy_start;
    int lat;
    launch(8'd200, 8'd7);
    @(negedge clk);
    @(negedge clk);
    s0_start = 1'b1; s0_a = 8'd9; s0_b = 8'd3;
    @(negedge clk);
    s0_start = 1'b0;
    wait_done(3, lat);
    chk("R7", "latency with intruding start", lat, LAT0);
    chk("R7", "quotient kept", int'(q0), 28);
    chk("R7", "remainder kept", int'(r0), 4);
    begin
      int extra = 0;
      for (int i = 0; i < LAT0 + 4; i++) begin
        @(negedge clk);
        if (done0 || busy0) extra++;
      end
      chk("R7", "no second division", extra, 0);
    end
  endtask

  task automatic t_hold;
    int lat;
    int mism = 0;
    div_and_check(8'd99, 8'd8);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (q0 != 8'd12 || r0 != 8'd3 || v0 != 1'b0) mism++;
    end
    chk("R8", "hold while idle", mism, 0);
    launch(8'd50, 8'd0);
    mism = 0;
    for (int i = 1; i < LAT0; i++) begin
      if (q0 != 8'd12 || r0 != 8'd3 || v0 != 1'b0) mism++;
      @(negedge clk);
    end
    chk("R8", "hold while running", mism, 0);
    wait_done(LAT0 - 1, lat);
    chk("R5", "new result after hold", int'(r0), 50);
  endtask

  task automatic t_small_exhaustive;
    int mism = 0;
    int latbad = 0;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int lat = 0;
        int eq = (b == 0) ? 15 : a / b;
        int er = (b == 0) ? a : a % b;
        @(negedge clk);
        s1_start = 1'b1; s1_a = 4'(a); s1_b = 4'(b);
        @(negedge clk);
        s1_start = 1'b0;
        while (!done1 && lat < 100) begin
          @(negedge clk);
          lat++;
        end
        if (lat != LAT1) latbad++;
        if (int'(q1) != eq || int'(r1) != er || int'(v1) != int'(b == 0) || c1 != 1'b0) begin
          mism++;
          $display("FAIL R1 R2 R5 width4 %0d/%0d: actual q=%0d r=%0d v=%0d expected q=%0d r=%0d v=%0d",
                   a, b, q1, r1, v1, eq, er, int'(b == 0));
        end
      end
    end
    total++;
    if (mism != 0) bad++;
    chk("R6", "width4 latency errors", latbad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_example();
    t_patterns();
    t_zero_div();
    t_busy_start();
    t_hold();
    t_small_exhaustive();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule